// File: doc/BRIEF.md
# Parallel RGB LCD Timing Generator

This block produces the line and frame timing for an 800x480 parallel panel that takes 24-bit color (8 bits each for red, green and blue) and has only sync inputs, with no data-enable line. It runs on the pixel clock, which is nominally about 33 MHz. A horizontal position counter runs over a 1056-clock line. A vertical counter runs over a 525-line frame and steps once per line. Together they give about 60 frames per second. Both sync outputs are active low, and each pulse starts a blanking interval. The horizontal blanking is 46 clocks counted from the start of the pulse, followed by 800 visible clocks and a 210-clock front porch. The vertical blanking is 23 lines from the start of its pulse, followed by 480 visible lines and a 22-line front porch.

Because the panel cannot be told which clocks carry pixels, the block drives the pixel source itself. A request output rises one clock before the first visible pixel of each visible line, and column and row outputs give the coordinates of the pixel being requested. The source answers within the same clock. The block registers the answer, so the colour appears at the panel pins on the visible clock that follows. At all other times the colour pins are held at zero. Generating the clock, storing the pixels and sequencing the panel power are handled elsewhere.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts H_BLANK+H_ACTIVE+H_FRONT clocks (1056 by default). `lcd_hsync_n` is low (active) for the first H_SYNC clocks of each line (default 20, allowed 1..40) and high for the rest of the line.
- R2: The vertical position advances only when the line wraps. `lcd_vsync_n` is low for the first V_SYNC lines of a frame (default 10, allowed 1..20). It changes level only on a clock where `lcd_hsync_n` falls.
- R3: `pix_req` is high when the horizontal position is in H_BLANK-1 .. H_BLANK+H_ACTIVE-2 on lines V_BLANK .. V_BLANK+V_ACTIVE-1, and low at every other position.
- R4: While `pix_req` is high, `pix_col` is the requested pixel's column. It is 0 on the first request clock of a line and rises by 1 each clock. `pix_row` is the visible line index (line number minus V_BLANK). Both are 0 while `pix_req` is low.
- R5: The colour outputs {`lcd_red`,`lcd_grn`,`lcd_blu`} equal the {`red_i`,`grn_i`,`blu_i`} values present during the previous clock when `pix_req` was high in that clock, and are all zero otherwise.
- R6: Asserting `rst_n` low, asynchronously, puts both positions at 0, which is the start of both sync pulses. `lcd_hsync_n` and `lcd_vsync_n` are then 0 and all other outputs are 0. The first clock edge after release moves to horizontal position 1.
- R7: After V_BLANK+V_ACTIVE+V_FRONT lines the frame wraps to line 0 and position 0, and both sync pulses start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| red_i | input | 8 | Red value from the pixel source for the requested pixel |
| grn_i | input | 8 | Green value from the pixel source |
| blu_i | input | 8 | Blue value from the pixel source |
| pix_req | output | 1 | Request for the pixel at pix_col/pix_row |
| pix_col | output | $clog2(H_ACTIVE) | Column of the requested pixel |
| pix_row | output | $clog2(V_ACTIVE) | Row of the requested pixel |
| lcd_hsync_n | output | 1 | Horizontal sync, active low |
| lcd_vsync_n | output | 1 | Vertical sync, active low |
| lcd_red | output | 8 | Red to the panel |
| lcd_grn | output | 8 | Green to the panel |
| lcd_blu | output | 8 | Blue to the panel |

## Verification
The sync, request, column and row outputs are registered from the next position. After the k-th clock edge following reset release they therefore describe position k itself. The bench counts edges from release and samples on the falling edge after edge k, comparing against a position computed from k alone. A colour value is due one edge after the clock in which it was presented with the request high. For this reason the bench drives a new colour pattern after every edge and expects, after edge k, the pattern it drove after edge k-1 if that position carried a request, and zero if it did not. Reset is checked before any edge, because its assertion is asynchronous.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // True when pos lies in [lo, lo+len).
  function automatic logic in_span(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

endpackage

// File: rtl/lcdt_wrap_counter.sv
module lcdt_wrap_counter #(
  parameter int TOTAL = 1056,
  localparam int W = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);

  always_comb begin
    wrap    = adv && (cnt_q == W'(TOTAL - 1));
    cnt_nxt = cnt_q;
    if (adv) begin
      cnt_nxt = wrap ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/lcdt_sync_decode.sv
module lcdt_sync_decode
  import lcdt_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_BLANK  = 46,
  parameter int H_SYNC   = 20,
  parameter int V_ACTIVE = 480,
  parameter int V_BLANK  = 23,
  parameter int V_SYNC   = 10,
  parameter int HW = 11,
  parameter int VW = 10,
  localparam int CW = $clog2(H_ACTIVE),
  localparam int RW = $clog2(V_ACTIVE)
) (
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  output logic          hs_n,
  output logic          vs_n,
  output logic          req,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row
);

  always_comb begin
    hs_n = !(int'(h_pos) < H_SYNC);
    vs_n = !(int'(v_pos) < V_SYNC);
    req  = in_span(int'(h_pos), H_BLANK - 1, H_ACTIVE) &&
           in_span(int'(v_pos), V_BLANK, V_ACTIVE);
    col  = req ? CW'(int'(h_pos) - (H_BLANK - 1)) : '0;
    row  = req ? RW'(int'(v_pos) - V_BLANK) : '0;
  end

endmodule

// File: rtl/lcdt_pixel_path.sv
module lcdt_pixel_path #(
  parameter int CBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CBITS-1:0] red_in,
  input  logic [CBITS-1:0] grn_in,
  input  logic [CBITS-1:0] blu_in,
  output logic [CBITS-1:0] red_q,
  output logic [CBITS-1:0] grn_q,
  output logic [CBITS-1:0] blu_q
);

  logic [CBITS-1:0] red_d, grn_d, blu_d;

  always_comb begin
    red_d = take ? red_in : '0;
    grn_d = take ? grn_in : '0;
    blu_d = take ? blu_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_q <= '0;
      grn_q <= '0;
      blu_q <= '0;
    end else begin
      red_q <= red_d;
      grn_q <= grn_d;
      blu_q <= blu_d;
    end
  end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int H_ACTIVE = 800,
  parameter int H_BLANK  = 46,
  parameter int H_FRONT  = 210,
  parameter int H_SYNC   = 20,
  parameter int V_ACTIVE = 480,
  parameter int V_BLANK  = 23,
  parameter int V_FRONT  = 22,
  parameter int V_SYNC   = 10,
  parameter int CBITS    = 8,
  localparam int CW = $clog2(H_ACTIVE),
  localparam int RW = $clog2(V_ACTIVE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CBITS-1:0] red_i,
  input  logic [CBITS-1:0] grn_i,
  input  logic [CBITS-1:0] blu_i,
  output logic             pix_req,
  output logic [CW-1:0]    pix_col,
  output logic [RW-1:0]    pix_row,
  output logic             lcd_hsync_n,
  output logic             lcd_vsync_n,
  output logic [CBITS-1:0] lcd_red,
  output logic [CBITS-1:0] lcd_grn,
  output logic [CBITS-1:0] lcd_blu
);

  localparam int H_TOTAL = H_BLANK + H_ACTIVE + H_FRONT;
  localparam int V_TOTAL = V_BLANK + V_ACTIVE + V_FRONT;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] h_q, h_nxt;
  logic [VW-1:0] v_q, v_nxt;
  logic          h_wrap, v_wrap;

  logic          hs_n_d, vs_n_d, req_d;
  logic [CW-1:0] col_d;
  logic [RW-1:0] row_d;

  // Horizontal position runs every clock; the vertical one is enabled only on a line wrap.
  lcdt_wrap_counter #(.TOTAL(H_TOTAL)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv(1'b1),
    .cnt_q(h_q), .cnt_nxt(h_nxt), .wrap(h_wrap)
  );

  lcdt_wrap_counter #(.TOTAL(V_TOTAL)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .adv(h_wrap),
    .cnt_q(v_q), .cnt_nxt(v_nxt), .wrap(v_wrap)
  );

  // Decode the position that the counters move to, so that the output registers line up with it.
  lcdt_sync_decode #(
    .H_ACTIVE(H_ACTIVE), .H_BLANK(H_BLANK), .H_SYNC(H_SYNC),
    .V_ACTIVE(V_ACTIVE), .V_BLANK(V_BLANK), .V_SYNC(V_SYNC),
    .HW(HW), .VW(VW)
  ) u_dec (
    .h_pos(h_nxt), .v_pos(v_nxt),
    .hs_n(hs_n_d), .vs_n(vs_n_d), .req(req_d), .col(col_d), .row(row_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcd_hsync_n <= 1'b0;
      lcd_vsync_n <= 1'b0;
      pix_req     <= 1'b0;
      pix_col     <= '0;
      pix_row     <= '0;
    end else begin
      lcd_hsync_n <= hs_n_d;
      lcd_vsync_n <= vs_n_d;
      pix_req     <= req_d;
      pix_col     <= col_d;
      pix_row     <= row_d;
    end
  end

  lcdt_pixel_path #(.CBITS(CBITS)) u_pix (
    .clk(clk), .rst_n(rst_n), .take(pix_req),
    .red_in(red_i), .grn_in(grn_i), .blu_in(blu_i),
    .red_q(lcd_red), .grn_q(lcd_grn), .blu_q(lcd_blu)
  );

  logic unused_ok;
  assign unused_ok = ^{h_q, v_q, v_wrap};

endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk #(
  parameter int H_ACTIVE = 800,
  parameter int H_BLANK  = 46,
  parameter int H_FRONT  = 210,
  parameter int H_SYNC   = 20,
  parameter int V_ACTIVE = 480,
  parameter int CBITS    = 8,
  localparam int CW = $clog2(H_ACTIVE),
  localparam int RW = $clog2(V_ACTIVE),
  localparam int LW = $clog2(H_BLANK + H_ACTIVE + H_FRONT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CBITS-1:0] red_i,
  input logic [CBITS-1:0] grn_i,
  input logic [CBITS-1:0] blu_i,
  input logic             pix_req,
  input logic [CW-1:0]    pix_col,
  input logic [RW-1:0]    pix_row,
  input logic             lcd_hsync_n,
  input logic             lcd_vsync_n,
  input logic [CBITS-1:0] lcd_red,
  input logic [CBITS-1:0] lcd_grn,
  input logic [CBITS-1:0] lcd_blu
);

  logic          past_ok;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      low_run <= '0;
    end else begin
      past_ok <= 1'b1;
      low_run <= lcd_hsync_n ? '0 : low_run + LW'(1);
    end
  end

  // R1
  hsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(lcd_hsync_n) |-> low_run == LW'(H_SYNC));

  // R2
  vsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (lcd_vsync_n != $past(lcd_vsync_n)) |-> $fell(lcd_hsync_n));

  // R3
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(pix_req) |-> lcd_hsync_n && (pix_col == '0));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_req && $past(pix_req) |-> pix_col == CW'($past(pix_col) + CW'(1)));

  // R4
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_req && $past(pix_req) |-> $stable(pix_row));

  // R5
  rgb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(pix_req) |->
      (lcd_red == $past(red_i)) && (lcd_grn == $past(grn_i)) && (lcd_blu == $past(blu_i)));

  // R5
  rgb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(pix_req) |-> {lcd_red, lcd_grn, lcd_blu} == '0);

endmodule

bind lcd_timing_gen lcd_timing_chk #(
  .H_ACTIVE(H_ACTIVE), .H_BLANK(H_BLANK), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
  .V_ACTIVE(V_ACTIVE), .CBITS(CBITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
  .pix_req(pix_req), .pix_col(pix_col), .pix_row(pix_row),
  .lcd_hsync_n(lcd_hsync_n), .lcd_vsync_n(lcd_vsync_n),
  .lcd_red(lcd_red), .lcd_grn(lcd_grn), .lcd_blu(lcd_blu)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;

  // Reduced geometry: line = 6+16+5 = 27 clocks, frame = 3+4+2 = 9 lines.
  localparam int HA = 16, HB = 6, HF = 5, HS = 3;
  localparam int VA = 4,  VB = 3, VF = 2, VS = 2;

  logic       clk, rst_n;
  logic [7:0] red_i, grn_i, blu_i;
  logic       pix_req, lcd_hsync_n, lcd_vsync_n;
  logic [3:0] pix_col;
  logic [1:0] pix_row;
  logic [7:0] lcd_red, lcd_grn, lcd_blu;

  lcd_timing_gen #(
    .H_ACTIVE(HA), .H_BLANK(HB), .H_FRONT(HF), .H_SYNC(HS),
    .V_ACTIVE(VA), .V_BLANK(VB), .V_FRONT(VF), .V_SYNC(VS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .pix_req(pix_req), .pix_col(pix_col), .pix_row(pix_row),
    .lcd_hsync_n(lcd_hsync_n), .lcd_vsync_n(lcd_vsync_n),
    .lcd_red(lcd_red), .lcd_grn(lcd_grn), .lcd_blu(lcd_blu)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] k;    // edges since reset release
    logic        hs;
    logic        vs;
    logic        rq;
    logic [3:0]  col;
    logic [1:0]  row;
    logic        rgb_on; // expect pattern of edge k-1, else zero
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{32'd0,   1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'd6}, // R6 reset state
    '{32'd2,   1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'd1}, // R1 h2 still in pulse
    '{32'd3,   1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'd1}, // R1 pulse ends at h3
    '{32'd27,  1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'd1}, // R1 next line at 27
    '{32'd54,  1'b0, 1'b1, 1'b0, 4'd0,  2'd0, 1'b0, 8'd2}, // R2 vsync ends at line 2
    '{32'd85,  1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 1'b0, 8'd3}, // R3 h4 v3 no request
    '{32'd86,  1'b1, 1'b1, 1'b1, 4'd0,  2'd0, 1'b0, 8'd3}, // R3 h5 first request
    '{32'd87,  1'b1, 1'b1, 1'b1, 4'd1,  2'd0, 1'b1, 8'd5}, // R5 first pixel out
    '{32'd101, 1'b1, 1'b1, 1'b1, 4'd15, 2'd0, 1'b1, 8'd4}, // R4 last request col 15
    '{32'd102, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 1'b1, 8'd5}, // R5 last pixel out
    '{32'd103, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 1'b0, 8'd5}, // R5 front porch zero
    '{32'd167, 1'b1, 1'b1, 1'b1, 4'd0,  2'd3, 1'b0, 8'd4}, // R4 last row 3
    '{32'd194, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 1'b0, 8'd3}, // R3 front porch line
    '{32'd243, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'd7}, // R7 frame wrap
    '{32'd248, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'd7}  // R7 line 0 no request
  };

  function automatic logic [23:0] pat(input int k);
    return {8'(k), 8'(k ^ 8'h5A), 8'(k + 17)};
  endfunction

  task automatic drive();
    {red_i, grn_i, blu_i} = pat(cur);
  endtask

  task automatic step();
    @(posedge clk);
    cur++;
    @(negedge clk);
    drive();
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, cur, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cur   = 0;
    drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      logic [23:0] exp_rgb;
      while (cur < int'(TBL[i].k)) step();
      rq = $sformatf("R%0d", TBL[i].tag);
      exp_rgb = TBL[i].rgb_on ? pat(cur - 1) : 24'h0;
      check({rq, " sync/req/col/row"},
            64'({lcd_hsync_n, lcd_vsync_n, pix_req, pix_col, pix_row}),
            64'({TBL[i].hs, TBL[i].vs, TBL[i].rq, TBL[i].col, TBL[i].row}));
      check({rq, " rgb"}, 64'({lcd_red, lcd_grn, lcd_blu}), 64'(exp_rgb));
    end

    // R6: asynchronous reset mid-line during requests, then restart from position 0
    while (cur < 9 * 27 + 3 * 27 + 10) step();
    check("R4 mid-line col before reset", 64'(pix_col), 64'd5);
    rst_n = 1'b0;
    #1;
    check("R6 async reset outputs",
          64'({lcd_hsync_n, lcd_vsync_n, pix_req, pix_col, pix_row, lcd_red, lcd_grn, lcd_blu}),
          64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cur = 0;
    step(); step();
    check("R6 h2 after release hsync low", 64'(lcd_hsync_n), 64'd0);
    step();
    check("R6 h3 after release hsync high", 64'({lcd_hsync_n, lcd_vsync_n}), 64'b10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule